// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block behaves like a small serial EEPROM slave on a three-wire chip-select, clock and data-in bus, with one data-out line. Its storage is a register array of 64 words of 16 bits. A host raises chip select and clocks in a frame. The frame begins with a 1 start bit, followed by a 2-bit opcode and a 6-bit address. Write-type commands carry a further 16 data bits. The engine supports word read, word write, word erase, whole-array erase, whole-array write, and the write-enable and write-disable commands.

Program commands (write, erase, erase-all, write-all) start a self-timed cycle on the falling edge of chip select that ends the frame. The cycle then runs without further bus clocks. An internal counter stands in for the nonvolatile write time. Erase-all and single-word cycles last `ERAL_TICKS` system clocks, and write-all lasts twice that because it includes its own erase. If chip select is raised again while a cycle runs, data-out reports busy (0) or ready (1). The bus inputs are sampled in the system clock domain, and the serial clock must be slow enough that each of its levels spans at least two system clocks. Data-out is modelled as a data bit plus an output-enable.

Top module: `uwire_eeprom`

## Requirements
- R1: After reset the array holds 16'hFFFF in every word, writes are disabled, no cycle is running and `do_oe` is 0.
- R2: Opcode 10 reads a word. The bit presented after the rising serial clock edge that takes the last address bit is data bit 15. Each further rising edge presents the next lower bit, down to bit 0.
- R3: When enabled, opcode 01 with 16 data bits (MSB first) writes that word, and opcode 11 sets the addressed word to 16'hFFFF. Each cycle lasts ERAL_TICKS clocks after the chip-select fall.
- R4: Opcode 00 with address bits [5:4]=10 (erase-all) sets every word to 16'hFFFF in a cycle of ERAL_TICKS clocks.
- R5: Opcode 00 with address bits [5:4]=01 plus 16 data bits (write-all) fills every word with that data, with no separate erase needed. Its cycle lasts 2*ERAL_TICKS clocks.
- R6: While writes are disabled, write, erase, erase-all and write-all change no word and start no cycle. Raising chip select afterwards leaves `do_oe` at 0.
- R7: While chip select is high after a program cycle has started, and before any new start bit is seen, `do_oe` is 1 and `do_data` is 0 while busy and 1 once ready.
- R8: Any command frame completed while a cycle is busy is discarded.
- R9: While chip select is low, `do_oe` is 0.
- R10: Opcode 00 with address bits [5:4]=11 enables writes, and [5:4]=00 disables them again.
- R11: Zero bits clocked in before the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cs | input | 1 | Chip select, active high |
| sck | input | 1 | Serial bus clock, sampled by clk |
| di | input | 1 | Serial data in, taken on rising sck |
| do_data | output | 1 | Serial data out / ready-busy flag |
| do_oe | output | 1 | Output enable for do_data |

## Verification
The hardest state to reach is a complete command arriving while a self-timed cycle is still counting. To get there, the bench starts a write-all cycle, which is the longest cycle. It then clocks in a full 25-bit write frame before that cycle ends, waits for ready, and reads the target address back to show the late write never landed. The exact cycle lengths are measured from the ports by raising chip select shortly after the fall and counting clocks until the ready flag appears.

// File: rtl/uwire_pkg.sv
package uwire_pkg;
  typedef enum logic [2:0] {
    ACT_NONE, ACT_READ, ACT_WRITE, ACT_ERASE,
    ACT_ERAL, ACT_WRAL, ACT_EWEN, ACT_EWDS
  } act_t;

  typedef enum logic [2:0] {
    F_IDLE, F_HDR, F_DATA, F_READ, F_DONE
  } fstate_t;

  localparam logic [1:0] OP_SPECIAL = 2'b00;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] OP_ERASE   = 2'b11;

  function automatic act_t decode_act(input logic [1:0] op, input logic [1:0] hi);
    case (op)
      OP_READ:  return ACT_READ;
      OP_WRITE: return ACT_WRITE;
      OP_ERASE: return ACT_ERASE;
      default: begin
        case (hi)
          2'b00:   return ACT_EWDS;
          2'b01:   return ACT_WRAL;
          2'b10:   return ACT_ERAL;
          default: return ACT_EWEN;
        endcase
      end
    endcase
  endfunction

  function automatic logic carries_data(input logic [1:0] op, input logic [1:0] hi);
    return (op == OP_WRITE) || (op == OP_SPECIAL && hi == 2'b01);
  endfunction

  function automatic logic is_program(input act_t a);
    return (a == ACT_WRITE) || (a == ACT_ERASE) || (a == ACT_ERAL) || (a == ACT_WRAL);
  endfunction

  function automatic int unsigned ticks_for(input act_t a, input int unsigned base);
    return (a == ACT_WRAL) ? 2 * base : base;
  endfunction
endpackage

// File: rtl/uwire_frame.sv
module uwire_frame
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs,
  input  logic              sck,
  input  logic              di,
  input  logic              busy,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              frame_done,
  output logic [1:0]        op,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic              rd_active,
  output logic              rd_bit,
  output logic              start_seen,
  output logic              cs_fall
);
  localparam int HDR_W  = 2 + ADDR_W;
  localparam int MAXB   = (HDR_W > DATA_W) ? HDR_W : DATA_W;
  localparam int BIT_CW = $clog2(MAXB + 1);

  fstate_t           st;
  logic              sck_q, cs_q;
  logic [HDR_W-1:0]  hdr;
  logic [HDR_W-1:0]  hdr_next;
  logic [BIT_CW-1:0] cnt;
  logic [DATA_W-1:0] sreg;
  logic              sck_rise;

  assign sck_rise   = sck & ~sck_q;
  assign cs_fall    = ~cs & cs_q;
  assign hdr_next   = {hdr[HDR_W-2:0], di};
  assign rd_addr    = hdr_next[ADDR_W-1:0];
  assign op         = hdr[HDR_W-1 -: 2];
  assign addr       = hdr[ADDR_W-1:0];
  assign frame_done = (st == F_DONE);
  assign rd_active  = (st == F_READ);
  assign rd_bit     = sreg[DATA_W-1];
  assign start_seen = cs & sck_rise & (st == F_IDLE) & di;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= F_IDLE;
      sck_q <= 1'b0;
      cs_q  <= 1'b0;
      hdr   <= '0;
      cnt   <= '0;
      data  <= '0;
      sreg  <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs;
      if (!cs) begin
        st  <= F_IDLE;
        cnt <= '0;
      end else if (sck_rise) begin
        case (st)
          F_IDLE: if (di) begin
            st  <= F_HDR;
            cnt <= '0;
          end
          F_HDR: begin
            hdr <= hdr_next;
            cnt <= cnt + 1'b1;
            if (cnt == BIT_CW'(HDR_W - 1)) begin
              cnt <= '0;
              if (hdr_next[HDR_W-1 -: 2] == OP_READ) begin
                if (!busy) begin
                  st   <= F_READ;
                  sreg <= rd_word;
                end else begin
                  st <= F_DONE;
                end
              end else if (carries_data(hdr_next[HDR_W-1 -: 2], hdr_next[ADDR_W-1 -: 2])) begin
                st <= F_DATA;
              end else begin
                st <= F_DONE;
              end
            end
          end
          F_DATA: begin
            data <= {data[DATA_W-2:0], di};
            cnt  <= cnt + 1'b1;
            if (cnt == BIT_CW'(DATA_W - 1)) st <= F_DONE;
          end
          F_READ: sreg <= {sreg[DATA_W-2:0], 1'b0};
          default: ;
        endcase
      end
    end
  end

  // Zero bits ahead of the start bit keep the decoder idle
  assert_leading_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && sck_rise && st == F_IDLE && !di) |=> (st == F_IDLE));
endmodule

// File: rtl/uwire_timer.sv
module uwire_timer #(
  parameter int CNT_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] ticks,
  output logic             busy,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign busy = (cnt != '0);
  assign done = (cnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (start)  cnt <= ticks;
    else if (busy)   cnt <= cnt - 1'b1;
  end

  // A new cycle may only be launched when none is running
  assert_start_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
endmodule

// File: rtl/uwire_store.sv
module uwire_store
  import uwire_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply,
  input  act_t              kind,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_word
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  assign rd_word = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (apply) begin
      case (kind)
        ACT_WRITE: mem[wr_addr] <= wr_data;
        ACT_ERASE: mem[wr_addr] <= '1;
        ACT_ERAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        ACT_WRAL:  for (int i = 0; i < DEPTH; i++) mem[i] <= wr_data;
        default: ;
      endcase
    end
  end

  // Erase-all leaves the first and last words erased
  assert_eral_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && kind == ACT_ERAL) |=> (mem[0] == '1 && mem[DEPTH-1] == '1));
endmodule

// File: rtl/uwire_eeprom.sv
module uwire_eeprom
  import uwire_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 16,
  parameter int ERAL_TICKS = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sck,
  input  logic di,
  output logic do_data,
  output logic do_oe
);
  localparam int CNT_W = $clog2(2 * ERAL_TICKS + 1);

  logic              busy, done, frame_done, rd_active, rd_bit;
  logic              start_seen, cs_fall;
  logic [1:0]        op;
  logic [ADDR_W-1:0] addr, rd_addr, pend_addr;
  logic [DATA_W-1:0] data, rd_word, pend_data;
  act_t              act, pend_act;
  logic              wen, status_armed;
  logic              commit, launch;
  logic [CNT_W-1:0]  ticks;

  assign act    = decode_act(op, addr[ADDR_W-1 -: 2]);
  assign commit = cs_fall & frame_done & ~busy;
  assign launch = commit & is_program(act) & wen;
  assign ticks  = CNT_W'(ticks_for(act, ERAL_TICKS));

  uwire_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di), .busy(busy),
    .rd_word(rd_word), .rd_addr(rd_addr), .frame_done(frame_done), .op(op),
    .addr(addr), .data(data), .rd_active(rd_active), .rd_bit(rd_bit),
    .start_seen(start_seen), .cs_fall(cs_fall)
  );

  uwire_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(launch), .ticks(ticks),
    .busy(busy), .done(done)
  );

  uwire_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .apply(done), .kind(pend_act),
    .wr_addr(pend_addr), .wr_data(pend_data), .rd_addr(rd_addr), .rd_word(rd_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wen          <= 1'b0;
      status_armed <= 1'b0;
      pend_act     <= ACT_NONE;
      pend_addr    <= '0;
      pend_data    <= '0;
    end else begin
      if (commit && act == ACT_EWEN) wen <= 1'b1;
      if (commit && act == ACT_EWDS) wen <= 1'b0;
      if (launch) begin
        pend_act     <= act;
        pend_addr    <= addr;
        pend_data    <= data;
        status_armed <= 1'b1;
      end else if ((start_seen || cs_fall) && !busy) begin
        status_armed <= 1'b0;
      end
    end
  end

  always_comb begin
    do_oe   = 1'b0;
    do_data = 1'b0;
    if (cs && rd_active) begin
      do_oe   = 1'b1;
      do_data = rd_bit;
    end else if (cs && status_armed) begin
      do_oe   = 1'b1;
      do_data = ~busy;
    end
  end

  // Program frames finished while disabled must not start a cycle
  assert_disabled_no_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_fall && frame_done && !busy && !wen && is_program(act)) |=> !busy);

  // Enable state cannot change through a frame that ends during a cycle
  assert_busy_keeps_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs_fall) |=> (wen == $past(wen)));
endmodule

// File: tb/sim_uwire_eeprom.sv
`timescale 1ns/1ps
module sim_uwire_eeprom;
  localparam int N = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs = 1'b0, sck = 1'b0, di = 1'b0;
  logic do_data, do_oe;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] model [64];
  logic [15:0] exp_q [$];
  logic [15:0] got_q [$];
  string       tag_q [$];

  always #2 clk = ~clk;

  uwire_eeprom #(.ADDR_W(6), .DATA_W(16), .ERAL_TICKS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sck(sck), .di(di),
    .do_data(do_data), .do_oe(do_oe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic b);
    @(negedge clk);
    di = b; sck = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sck = 1'b0;
    @(negedge clk);
  endtask

  task automatic send(input logic [24:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) pulse(v[i]);
  endtask

  // Sends a full frame; chip select drops at the final negedge
  task automatic frame(input logic [1:0] op, input logic [5:0] a,
                       input bit has_data, input logic [15:0] d);
    @(negedge clk);
    cs = 1'b1;
    send({16'h0, 1'b1, op, a}, 9);
    if (has_data) send({9'h0, d}, 16);
    cs = 1'b0;
  endtask

  task automatic run_cycle(input int n, input string req);
    int  first = -1;
    bit  bad = 0;
    @(negedge clk);
    @(negedge clk);
    cs = 1'b1;
    for (int k = 2; k <= 4 * n; k++) begin
      @(negedge clk);
      if (!do_oe) bad = 1;
      if (do_data) begin first = k; break; end
    end
    check(first == n, req, first, n);
    check(!bad, "R7", bad, 0);
    cs = 1'b0;
    #1;
    check(do_oe == 1'b0, "R9", do_oe, 0);
    @(negedge clk);
  endtask

  task automatic do_read(input logic [5:0] a, input int pre, input string req);
    logic [15:0] w;
    exp_q.push_back(model[a]);
    tag_q.push_back(req);
    @(negedge clk);
    cs = 1'b1;
    if (pre > 0) send(25'h0, pre);
    send({16'h0, 1'b1, 2'b10, a}, 9);
    w[15] = do_data;
    for (int i = 14; i >= 0; i--) begin
      pulse(1'b0);
      w[i] = do_data;
    end
    cs = 1'b0;
    got_q.push_back(w);
    @(negedge clk);
  endtask

  // Monitor: pairs each captured word with its expected value
  initial begin
    forever begin
      wait (got_q.size() > 0);
      begin
        logic [15:0] g, e;
        string t;
        g = got_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(g == e, t, g, e);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(do_oe == 1'b0, "R1", do_oe, 0);
    do_read(6'd0, 0, "R1");

    // R6: write while disabled
    frame(2'b01, 6'd3, 1, 16'hA5A5);
    @(negedge clk);
    cs = 1'b1;
    repeat (3) @(negedge clk);
    check(do_oe == 1'b0, "R6", do_oe, 0);
    cs = 1'b0;
    do_read(6'd3, 0, "R6");

    // R10: enable, then single word operations (R3)
    frame(2'b00, 6'h30, 0, 16'h0);
    frame(2'b01, 6'd3, 1, 16'h1234);
    run_cycle(N, "R3");
    model[3] = 16'h1234;
    do_read(6'd3, 0, "R2");
    frame(2'b01, 6'd63, 1, 16'hBEEF);
    run_cycle(N, "R3");
    model[63] = 16'hBEEF;
    do_read(6'd63, 0, "R2");
    frame(2'b11, 6'd3, 0, 16'h0);
    run_cycle(N, "R3");
    model[3] = 16'hFFFF;
    do_read(6'd3, 0, "R3");
    do_read(6'd63, 3, "R11");

    // R5: write-all
    frame(2'b00, 6'h10, 1, 16'h5A3C);
    run_cycle(2 * N, "R5");
    for (int i = 0; i < 64; i++) model[i] = 16'h5A3C;
    do_read(6'd0, 0, "R5");
    do_read(6'd17, 0, "R5");
    do_read(6'd63, 0, "R5");

    // R8: a write frame arriving during a write-all cycle is dropped
    frame(2'b00, 6'h10, 1, 16'hC3C3);
    repeat (2) @(negedge clk);
    frame(2'b01, 6'd5, 1, 16'h0000);
    @(negedge clk);
    cs = 1'b1;
    for (int k = 0; k < 4 * N; k++) begin
      @(negedge clk);
      if (do_data) break;
    end
    check(do_oe && do_data, "R7", {do_oe, do_data}, 3);
    cs = 1'b0;
    for (int i = 0; i < 64; i++) model[i] = 16'hC3C3;
    do_read(6'd5, 0, "R8");
    do_read(6'd6, 0, "R8");

    // R4: erase-all
    frame(2'b00, 6'h20, 0, 16'h0);
    run_cycle(N, "R4");
    for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
    do_read(6'd5, 0, "R4");
    do_read(6'd40, 0, "R4");

    // R10: disable again, write must be ignored
    frame(2'b00, 6'h00, 0, 16'h0);
    frame(2'b01, 6'd1, 1, 16'h7777);
    @(negedge clk);
    cs = 1'b1;
    repeat (3) @(negedge clk);
    check(do_oe == 1'b0, "R10", do_oe, 0);
    cs = 1'b0;
    do_read(6'd1, 0, "R10");

    wait (got_q.size() == 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule